// File: doc/BRIEF.md
# Half-Duplex ADC Read Controller

This block is the host side of a three-wire link to a 12-bit serial converter. The link has a chip select, a serial clock, and one data line that both sides share. A request carries four things: a channel code, a clock divider, an inter-frame gap and a verify option. When the controller accepts a request, it pulls chip select low and sends a start bit of 1. It then sends the channel code as the configuration word, most significant bit first. After that it turns the shared line around. It stops driving on the falling serial-clock edge that follows the last configuration bit, so that host and converter never drive the line at the same time.

After the turnaround the converter sends one null bit, which is thrown away. The next twelve rising edges deliver the result MSB first. When verify is requested, eleven more rising edges receive the LSB-first copy (bits 1 through 11). Each of those bits is compared with the word already captured, and any difference sets a mismatch flag. The frame ends when chip select returns high. At that moment the word, its channel tag and the mismatch flag are presented with a single-cycle valid pulse. Chip select then stays high for a programmable number of system clocks before the next request can be taken.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the data driver is off, valid is low and the controller is ready.
- R2: A request is taken only when ready is high. A request raised during a frame has no effect: that frame's tag is unchanged and no extra frame follows it.
- R3: Each serial-clock level lasts exactly the requested divider in system clocks, with a divider of 0 treated as 1. The serial clock is low whenever chip select is high.
- R4: On the first four rising edges of a frame the host presents a 1 and then the 3-bit channel code, MSB first. The host's output bit changes only on the cycle in which the serial clock falls.
- R5: The data driver is on from the start of the frame through the fourth rising edge. It turns off on the falling edge that follows the fourth rising edge, and it is never on while chip select is high.
- R6: The fifth rising edge (the null bit) is discarded. Rising edges 6 through 17 are assembled into the result word, with edge 6 giving bit 11 and edge 17 giving bit 0.
- R7: A frame contains exactly 17 rising edges without verify and 28 with verify. Chip select rises on the falling edge after the last rising edge.
- R8: With verify on, rising edges 18 through 28 are compared with result bits 1 through 11 in that order, and the mismatch output is 1 if any of them differ. With verify off, the mismatch output is 0.
- R9: The valid output is a one-cycle pulse in the cycle in which chip select has just risen. The word, tag and mismatch outputs hold their values until the next frame ends.
- R10: When a request is already waiting, chip select stays high for exactly the requested gap plus 2 system clocks between two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken when ready is high |
| req_chan_i | input | 3 | Channel code sent as the configuration word |
| req_div_i | input | 8 | Serial-clock half period in system clocks (0 acts as 1) |
| req_gap_i | input | 8 | Extra chip-select high time after the frame |
| req_verify_i | input | 1 | Also read and compare the LSB-first copy |
| req_ready_o | output | 1 | Controller is idle and takes a request |
| adc_cs_no | output | 1 | Chip select, active low |
| adc_sclk_o | output | 1 | Serial clock |
| adc_sdo_o | output | 1 | Host bit for the shared data line |
| adc_sdo_oe_o | output | 1 | Host driver enable for the shared data line |
| adc_sdi_i | input | 1 | Value present on the shared data line |
| rd_data_o | output | 12 | Assembled result word |
| rd_chan_o | output | 3 | Channel tag of the result |
| rd_valid_o | output | 1 | One-cycle result strobe |
| rd_mismatch_o | output | 1 | LSB-first copy disagreed with the word |

## Verification
Two behaviours cannot be observed from the result alone: the mismatch path and the turnaround. The bench contains a converter model that drives the shared line only after it sees the falling edge that follows the fourth rising edge. The model can flip a single bit of the LSB-first copy (bit 4), so the mismatch flag is reached while the MSB-first word stays correct. The same model records every level length, the host bits seen on the first four rising edges, and any cycle in which both drivers are on. A request issued partway through a frame and a request held across two frames are used to reach the ignore rule and the exact gap length.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } adcrd_state_e;
endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             tick;

  assign tick = run_i && (cnt_q == (half_i - DIV_W'(1)));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;
endmodule

// File: rtl/adcrd_tx_seq.sv
module adcrd_tx_seq #(
  parameter int CFG_W = 3,
  parameter int RC_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             fall_i,
  input  logic [RC_W-1:0]  rises_i,
  input  logic             end_i,
  output logic             sdo_o,
  output logic             oe_o
);
  logic [CFG_W-1:0] sh_q, sh_d;
  logic             sdo_q, sdo_d;
  logic             oe_q, oe_d;
  logic             in_cfg, at_release;

  assign in_cfg     = (rises_i >= RC_W'(1)) && (rises_i <= RC_W'(CFG_W));
  assign at_release = (rises_i == RC_W'(CFG_W + 1));

  always_comb begin
    sh_d  = sh_q;
    sdo_d = sdo_q;
    oe_d  = oe_q;
    if (load_i) begin
      sh_d  = cfg_i;
      sdo_d = 1'b1;
      oe_d  = 1'b1;
    end else if (end_i) begin
      sdo_d = 1'b0;
      oe_d  = 1'b0;
    end else if (fall_i) begin
      if (in_cfg) begin
        sdo_d = sh_q[CFG_W-1];
        sh_d  = {sh_q[CFG_W-2:0], 1'b0};
      end else if (at_release) begin
        sdo_d = 1'b0;
        oe_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;
endmodule

// File: rtl/adcrd_rx_capture.sv
module adcrd_rx_capture #(
  parameter int RES_W = 12,
  parameter int CFG_W = 3,
  parameter int RC_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             rise_i,
  input  logic [RC_W-1:0]  rises_i,
  input  logic             sdi_i,
  output logic [RES_W-1:0] word_o,
  output logic             mis_o
);
  localparam int WORD_LO = CFG_W + 2;
  localparam int WORD_HI = CFG_W + 1 + RES_W;
  localparam int ECHO_LO = WORD_HI + 1;
  localparam int ECHO_HI = WORD_HI + RES_W - 1;
  localparam int IDX_W   = $clog2(RES_W);

  logic [RES_W-1:0] word_q, word_d;
  logic             mis_q, mis_d;
  logic             in_word, in_echo;
  logic [RC_W-1:0]  ofs;
  logic [IDX_W-1:0] echo_idx;
  logic             echo_ref;

  assign in_word  = (rises_i >= RC_W'(WORD_LO)) && (rises_i <= RC_W'(WORD_HI));
  assign in_echo  = (rises_i >= RC_W'(ECHO_LO)) && (rises_i <= RC_W'(ECHO_HI));
  assign ofs      = rises_i - RC_W'(WORD_HI);
  assign echo_idx = ofs[IDX_W-1:0];
  assign echo_ref = word_q[echo_idx];

  always_comb begin
    word_d = word_q;
    mis_d  = mis_q;
    if (clear_i) begin
      word_d = '0;
      mis_d  = 1'b0;
    end else if (rise_i) begin
      if (in_word) begin
        word_d = {word_q[RES_W-2:0], sdi_i};
      end else if (in_echo && (sdi_i != echo_ref)) begin
        mis_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      mis_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      mis_q  <= mis_d;
    end
  end

  assign word_o = word_q;
  assign mis_o  = mis_q;
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int CFG_W = 3,
  parameter int DIV_W = 8,
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CFG_W-1:0] req_chan_i,
  input  logic [DIV_W-1:0] req_div_i,
  input  logic [GAP_W-1:0] req_gap_i,
  input  logic             req_verify_i,
  output logic             req_ready_o,
  output logic             adc_cs_no,
  output logic             adc_sclk_o,
  output logic             adc_sdo_o,
  output logic             adc_sdo_oe_o,
  input  logic             adc_sdi_i,
  output logic [RES_W-1:0] rd_data_o,
  output logic [CFG_W-1:0] rd_chan_o,
  output logic             rd_valid_o,
  output logic             rd_mismatch_o
);
  localparam int RISE_PLAIN = CFG_W + 2 + RES_W;
  localparam int RISE_ECHO  = RISE_PLAIN + RES_W - 1;
  localparam int RC_W       = $clog2(RISE_ECHO + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  adcrd_state_e     state_q, state_d;
  logic [CFG_W-1:0] chan_q, chan_d;
  logic [DIV_W-1:0] half_q, half_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] gcnt_q, gcnt_d;
  logic             ver_q, ver_d;
  logic [RC_W-1:0]  rises_q, rises_d;
  logic             cs_n_q, cs_n_d;
  logic [RES_W-1:0] data_q, data_d;
  logic [CFG_W-1:0] tag_q, tag_d;
  logic             valid_q, valid_d;
  logic             mis_q, mis_d;

  logic             accept, frame_end, running;
  logic             sclk, rise, fall;
  logic [RC_W-1:0]  last_rise;
  logic [RES_W-1:0] rx_word;
  logic             rx_mis;

  assign running   = (state_q == ST_RUN);
  assign accept    = (state_q == ST_IDLE) && req_i;
  assign last_rise = ver_q ? RC_W'(RISE_ECHO) : RC_W'(RISE_PLAIN);
  assign frame_end = running && fall && (rises_q == last_rise);

  adcrd_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .run_i  (running),
    .half_i (half_q),
    .sclk_o (sclk),
    .rise_o (rise),
    .fall_o (fall)
  );

  adcrd_tx_seq #(.CFG_W(CFG_W), .RC_W(RC_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .load_i  (accept),
    .cfg_i   (req_chan_i),
    .fall_i  (fall),
    .rises_i (rises_q),
    .end_i   (frame_end),
    .sdo_o   (adc_sdo_o),
    .oe_o    (adc_sdo_oe_o)
  );

  adcrd_rx_capture #(.RES_W(RES_W), .CFG_W(CFG_W), .RC_W(RC_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_q),
    .clear_i (accept),
    .rise_i  (rise && running),
    .rises_i (rises_q),
    .sdi_i   (adc_sdi_i),
    .word_o  (rx_word),
    .mis_o   (rx_mis)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    chan_d  = chan_q;
    half_d  = half_q;
    gap_d   = gap_q;
    gcnt_d  = gcnt_q;
    ver_d   = ver_q;
    rises_d = rises_q;
    cs_n_d  = cs_n_q;
    data_d  = data_q;
    tag_d   = tag_q;
    mis_d   = mis_q;
    valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          state_d = ST_RUN;
          chan_d  = req_chan_i;
          half_d  = (req_div_i == '0) ? DIV_W'(1) : req_div_i;
          gap_d   = req_gap_i;
          ver_d   = req_verify_i;
          rises_d = '0;
          cs_n_d  = 1'b0;
        end
      end
      ST_RUN: begin
        if (rise) begin
          rises_d = rises_q + RC_W'(1);
        end
        if (frame_end) begin
          state_d = ST_GAP;
          cs_n_d  = 1'b1;
          gcnt_d  = '0;
          data_d  = rx_word;
          tag_d   = chan_q;
          mis_d   = ver_q & rx_mis;
          valid_d = 1'b1;
        end
      end
      ST_GAP: begin
        if (gcnt_q >= gap_q) begin
          state_d = ST_IDLE;
        end else begin
          gcnt_d = gcnt_q + GAP_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      half_q  <= DIV_W'(1);
      gap_q   <= '0;
      gcnt_q  <= '0;
      ver_q   <= 1'b0;
      rises_q <= '0;
      cs_n_q  <= 1'b1;
      data_q  <= '0;
      tag_q   <= '0;
      valid_q <= 1'b0;
      mis_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      half_q  <= half_d;
      gap_q   <= gap_d;
      gcnt_q  <= gcnt_d;
      ver_q   <= ver_d;
      rises_q <= rises_d;
      cs_n_q  <= cs_n_d;
      data_q  <= data_d;
      tag_q   <= tag_d;
      valid_q <= valid_d;
      mis_q   <= mis_d;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign adc_cs_no     = cs_n_q;
  assign adc_sclk_o    = sclk;
  assign rd_data_o     = data_q;
  assign rd_chan_o     = tag_q;
  assign rd_valid_o    = valid_q;
  assign rd_mismatch_o = mis_q;
endmodule

// File: rtl/adcrd_ctrl_chk.sv
module adcrd_ctrl_chk #(
  parameter int GAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             req_ready_o,
  input logic [GAP_W-1:0] req_gap_i,
  input logic             adc_cs_no,
  input logic             adc_sclk_o,
  input logic             adc_sdo_o,
  input logic             adc_sdo_oe_o,
  input logic             rd_valid_o
);
  logic [GAP_W:0]   hi_cnt_q;
  logic [GAP_W-1:0] gap_lat_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q  <= '0;
      gap_lat_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      if (adc_cs_no) begin
        if (hi_cnt_q != '1) hi_cnt_q <= hi_cnt_q + 1'b1;
      end else begin
        hi_cnt_q <= '0;
      end
      if (req_i && req_ready_o) gap_lat_q <= req_gap_i;
      if (rd_valid_o) seen_q <= 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_no |-> !adc_sclk_o);  // R3
  AST_TX_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_sdo_oe_o && $past(adc_sdo_oe_o) && (adc_sdo_o != $past(adc_sdo_o))) |-> $fell(adc_sclk_o));  // R4
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_sdo_oe_o |-> !adc_cs_no);  // R5
  AST_READY_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> adc_cs_no);  // R2
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);  // R9
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $rose(adc_cs_no));  // R9
  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(adc_cs_no) && seen_q) |-> (hi_cnt_q >= ({1'b0, gap_lat_q} + 1'b1)));  // R10
endmodule

bind adcrd_ctrl adcrd_ctrl_chk #(.GAP_W(GAP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .req_ready_o  (req_ready_o),
  .req_gap_i    (req_gap_i),
  .adc_cs_no    (adc_cs_no),
  .adc_sclk_o   (adc_sclk_o),
  .adc_sdo_o    (adc_sdo_o),
  .adc_sdo_oe_o (adc_sdo_oe_o),
  .rd_valid_o   (rd_valid_o)
);

// File: tb/adcrd_ctrl_tb_top.sv
module adcrd_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req;
  logic [2:0]  req_chan;
  logic [7:0]  req_div;
  logic [7:0]  req_gap;
  logic        req_ver;
  logic        ready;
  logic        cs_n, sclk, sdo, oe, sdi;
  logic [11:0] rdata;
  logic [2:0]  rchan;
  logic        rvalid, rmis;

  int n_chk = 0;
  int n_bad = 0;

  // converter model state
  logic        prev_cs, prev_sclk;
  logic        m_oe, m_bit, m_corrupt;
  logic [11:0] m_word;
  logic [3:0]  m_tx;
  int m_rise, m_done, m_div_exp, lvl, hi, m_hi, m_frames;
  bit m_clkbad, m_txbad, m_contend;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  adcrd_ctrl dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .req_chan_i   (req_chan),
    .req_div_i    (req_div),
    .req_gap_i    (req_gap),
    .req_verify_i (req_ver),
    .req_ready_o  (ready),
    .adc_cs_no    (cs_n),
    .adc_sclk_o   (sclk),
    .adc_sdo_o    (sdo),
    .adc_sdo_oe_o (oe),
    .adc_sdi_i    (sdi),
    .rd_data_o    (rdata),
    .rd_chan_o    (rchan),
    .rd_valid_o   (rvalid),
    .rd_mismatch_o(rmis)
  );

  assign sdi = oe ? sdo : (m_oe ? m_bit : 1'b1);

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b0; m_oe = 1'b0; m_bit = 1'b0;
      m_rise = 0; m_done = 0; lvl = 0; hi = 0; m_hi = 0; m_frames = 0;
      m_tx = '0;
    end else begin
      if (cs_n) begin
        if (!prev_cs) m_done = m_rise;
        m_rise = 0; m_oe = 1'b0; lvl = 0; hi++;
      end else begin
        if (prev_cs) begin m_frames++; m_hi = hi; hi = 0; end
        if (sclk != prev_sclk) begin
          if (lvl != m_div_exp) m_clkbad = 1;
          lvl = 1;
          if (sclk) begin
            if (m_rise < 4) begin m_tx[3-m_rise] = sdi; if (!oe) m_txbad = 1; end
            m_rise++;
          end else begin
            if (m_rise == 4) begin if (oe) m_txbad = 1; m_oe = 1'b1; m_bit = 1'b0; end
            else if (m_rise >= 5 && m_rise <= 16) m_bit = m_word[16-m_rise];
            else if (m_rise >= 17 && m_rise <= 27)
              m_bit = m_word[m_rise-16] ^ (m_corrupt && m_rise == 20);
            else m_bit = 1'b0;
          end
        end else begin
          lvl++;
        end
      end
      if (oe && m_oe) m_contend = 1;
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !ready; i++) tick(1);
  endtask

  task automatic wait_valid(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      if (rvalid) begin seen = 1; break; end
      tick(1);
    end
  endtask

  task automatic setup_req(input logic [2:0] ch, input int dv, input int gp,
                           input bit ver, input logic [11:0] w, input bit cor);
    req_chan = ch; req_div = 8'(dv); req_gap = 8'(gp); req_ver = ver;
    m_word = w; m_corrupt = cor; m_div_exp = (dv == 0) ? 1 : dv;
    m_clkbad = 0; m_txbad = 0; m_contend = 0;
  endtask

  // R1
  task automatic t_reset();
    chk(cs_n == 1'b1, "R1 cs after reset", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
    chk(oe == 1'b0, "R1 driver after reset", oe, 0);
    chk(rvalid == 1'b0, "R1 valid after reset", rvalid, 0);
    chk(ready == 1'b1, "R1 ready after reset", ready, 1);
  endtask

  task automatic t_frame(input logic [2:0] ch, input int dv, input bit ver,
                         input logic [11:0] w, input bit cor);
    bit seen;
    wait_ready();
    setup_req(ch, dv, 0, ver, w, cor);
    req = 1'b1;
    tick(1);
    req = 1'b0;
    wait_valid(seen);
    chk(seen, "R9 valid pulse seen", seen, 1);
    chk(rdata == w, "R6 result word", rdata, w);
    chk(rchan == ch, "R2 channel tag", rchan, ch);
    chk(rmis == (ver && cor), "R8 mismatch flag", rmis, ver && cor);
    chk(cs_n == 1'b1, "R9 cs high with valid", cs_n, 1);
    @(negedge clk); #1;
    chk(m_done == (ver ? 28 : 17), "R7 rising edge count", m_done, ver ? 28 : 17);
    chk(m_tx == {1'b1, ch}, "R4 start and channel bits", m_tx, {1'b1, ch});
    chk(!m_clkbad, "R3 serial clock level length", m_clkbad, 0);
    chk(!m_txbad, "R5 driver release timing", m_txbad, 0);
    chk(!m_contend, "R5 no drive overlap", m_contend, 0);
    tick(1);
    chk(rvalid == 1'b0, "R9 valid one cycle", rvalid, 0);
    chk(rdata == w, "R9 word held", rdata, w);
  endtask

  // R2
  task automatic t_busy_ignore();
    bit seen;
    int f0;
    wait_ready();
    setup_req(3'd5, 2, 0, 1'b0, 12'h3C5, 1'b0);
    f0 = m_frames;
    req = 1'b1;
    tick(1);
    req = 1'b0;
    tick(30);
    req_chan = 3'd2;
    req = 1'b1;
    tick(1);
    req = 1'b0;
    wait_valid(seen);
    chk(rchan == 3'd5, "R2 tag unchanged by busy request", rchan, 5);
    tick(80);
    chk(m_frames - f0 == 1, "R2 no extra frame", m_frames - f0, 1);
    chk(cs_n == 1'b1, "R2 link idle after frame", cs_n, 1);
  endtask

  // R10
  task automatic t_gap(input int gp);
    bit seen;
    wait_ready();
    setup_req(3'd6, 1, gp, 1'b0, 12'hA5A, 1'b0);
    req = 1'b1;
    wait_valid(seen);
    tick(1);
    wait_valid(seen);
    req = 1'b0;
    chk(seen, "R10 second frame done", seen, 1);
    chk(m_hi == gp + 2, "R10 chip select gap", m_hi, gp + 2);
    tick(gp + 8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; req_chan = '0; req_div = '0; req_gap = '0; req_ver = 1'b0;
    m_word = '0; m_corrupt = 1'b0; m_div_exp = 1;
    m_clkbad = 0; m_txbad = 0; m_contend = 0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_frame(3'd3, 2, 1'b0, 12'hB3D, 1'b0);
    t_frame(3'd7, 0, 1'b0, 12'h801, 1'b1);
    t_frame(3'd1, 3, 1'b1, 12'h5E7, 1'b0);
    t_frame(3'd4, 1, 1'b1, 12'h69C, 1'b1);
    t_frame(3'd0, 5, 1'b1, 12'hFFF, 1'b0);
    t_busy_ignore();
    t_gap(0);
    t_gap(6);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule